// File: doc/BRIEF.md
# DRAM Strobe Cycle Classifier

This block watches the four active-low control strobes of an asynchronous DRAM bus: row strobe, column strobe, write enable and output enable. It samples them with a fast system clock. Each period in which the row strobe is low is sorted into one cycle type. The type is reported when the row strobe returns high. A bus analyser can log these codes, and a testbench can compare them against the commands a memory controller meant to issue.

The decision rests on the order in which the sampled strobe edges arrive, not on static levels. Three pairs are told apart this way:
- A write committed when the column strobe falls is separated from a write that arrives later.
- A refresh whose column strobe leads the row strobe is separated from the same sequence with write enable low.
- A refresh hidden behind a finished access is separated from a fresh refresh request.

A separate one-clock flag marks two protocol faults: a stray column-strobe pulse while the row strobe is high, and an access period held open for too long.

Top module: `dram_cycle_classifier`

## Requirements
- R1: `cyc_code` is updated only together with `cyc_valid` and holds its value otherwise. The codes are: 0 none (reset value), 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 page cycle, 6 row-only refresh, 7 column-before-row refresh, 8 test-mode entry, 9 hidden refresh, 10 self-refresh entry.
- R2: `cyc_valid` is a one-clock pulse. It appears two clocks after the clock edge that first samples `ras_n` high at the end of a low period, and it carries the code for that period.
- R3: If `cas_n` was already low on the sample before `ras_n` is first sampled low, and that low was not carried over from a previous access, the period is code 7 when `we_n` is high at that sample and code 8 when `we_n` is low.
- R4: An access period in which `cas_n` never falls yields code 6.
- R5: An access period with a single `cas_n` fall yields code 2 if `we_n` is low on the sample where `cas_n` falls. If `we_n` stays high, the period yields code 1.
- R6: With `we_n` high when `cas_n` falls, a later `we_n` fall while `cas_n` is low gives code 4 if `oe_n` has been low at any point since `cas_n` fell. It gives code 3 if `oe_n` stayed high. Code 4 outranks code 3.
- R7: Two or more `cas_n` falls within one access period give code 5. Code 5 outranks codes 1 to 4.
- R8: If `cas_n` stays low from the end of an access period until `ras_n` falls again, the new period yields code 9.
- R9: A code-7 period whose count of low samples exceeds `SREF_CYC` is reported as code 10. A count equal to `SREF_CYC` stays code 7.
- R10: A `cas_n` low pulse that begins and ends while `ras_n` is high raises `viol` for one clock, two clocks after `cas_n` is sampled high again.
- R11: `viol` pulses once when an access period with fewer than two `cas_n` falls reaches `max_low_clks` low samples. Only access periods are timed; refresh, test-mode and hidden periods are not.
- R12: A second `cas_n` fall on the very sample that reaches the limit prevents the pulse. A limit of 0 disables the check.
- R13: After reset, `cyc_valid`, `viol` and `cyc_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| max_low_clks | input | CNT_W | Low-sample limit for access periods, 0 disables |
| cyc_valid | output | 1 | One-clock strobe for a finished period |
| cyc_code | output | 4 | Cycle-type code |
| viol | output | 1 | One-clock protocol fault pulse |

## Verification
Two decisions can land on one sample, and the bench provokes both.

The first is the overlong-access limit and a page-mode column-strobe fall. A directed pattern places the second `cas_n` fall exactly on the sample where the low count equals `max_low_clks`. The bench expects code 5 and no `viol`. The same pattern with the limit one lower must produce exactly one `viol` pulse.

The second is the split between a hidden refresh and a new column-before-row refresh. Both start with `cas_n` low at the row-strobe fall. Random sequences interleave them so that the bench expects code 9 only when the column strobe was held over from an access, and code 7 or 10 otherwise.

// File: rtl/dcc_pkg.sv
package dcc_pkg;

    typedef enum logic [3:0] {
        CYC_NONE     = 4'd0,
        CYC_READ     = 4'd1,
        CYC_WR_EARLY = 4'd2,
        CYC_WR_LATE  = 4'd3,
        CYC_RMW      = 4'd4,
        CYC_PAGE     = 4'd5,
        CYC_RAS_ONLY = 4'd6,
        CYC_CBR      = 4'd7,
        CYC_TEST     = 4'd8,
        CYC_HIDDEN   = 4'd9,
        CYC_SELF     = 4'd10
    } cyc_e;

    // How a low period of the row strobe began
    typedef enum logic [1:0] {
        ENT_ACCESS = 2'd0,
        ENT_CBR    = 2'd1,
        ENT_TEST   = 2'd2,
        ENT_HIDDEN = 2'd3
    } entry_e;

    // Sampled electrical levels (1 = high)
    typedef struct packed {
        logic ras;
        logic cas;
        logic we;
        logic oe;
    } strobe_t;

    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
        logic cas_rise;
        logic we_fall;
        logic cas_pre_low;   // column strobe was low on the previous sample
    } edge_t;

    // Facts gathered during one row-strobe low period
    typedef struct packed {
        entry_e     entry;
        logic [1:0] ncas;     // saturating count of column-strobe falls
        logic       wr_early;
        logic       oe_seen;
        logic       wr_late;
        logic       rmw;
    } period_t;

    function automatic cyc_e classify(input period_t p, input logic long_low);
        cyc_e c;
        case (p.entry)
            ENT_CBR:    c = long_low ? CYC_SELF : CYC_CBR;
            ENT_TEST:   c = CYC_TEST;
            ENT_HIDDEN: c = CYC_HIDDEN;
            default: begin
                if (p.ncas == 2'd0)      c = CYC_RAS_ONLY;
                else if (p.ncas >= 2'd2) c = CYC_PAGE;
                else if (p.wr_early)     c = CYC_WR_EARLY;
                else if (p.rmw)          c = CYC_RMW;
                else if (p.wr_late)      c = CYC_WR_LATE;
                else                     c = CYC_READ;
            end
        endcase
        return c;
    endfunction

endpackage

// File: rtl/dcc_sampler.sv
module dcc_sampler
    import dcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t raw,
    output strobe_t cur,
    output edge_t   edges
);
    logic p_ras, p_cas, p_we;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= '1;
            p_ras <= 1'b1;
            p_cas <= 1'b1;
            p_we  <= 1'b1;
        end else begin
            cur   <= raw;
            p_ras <= cur.ras;
            p_cas <= cur.cas;
            p_we  <= cur.we;
        end
    end

    always_comb begin
        edges.ras_fall    = p_ras & ~cur.ras;
        edges.ras_rise    = ~p_ras & cur.ras;
        edges.cas_fall    = p_cas & ~cur.cas;
        edges.cas_rise    = ~p_cas & cur.cas;
        edges.we_fall     = p_we & ~cur.we;
        edges.cas_pre_low = ~p_cas;
    end
endmodule

// File: rtl/dcc_tracker.sv
module dcc_tracker
    import dcc_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  strobe_t          cur,
    input  edge_t            edges,
    input  logic [CNT_W-1:0] limit,
    output period_t          per,
    output logic [CNT_W-1:0] low_cnt,
    output logic             viol
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    period_t          per_n;
    logic [CNT_W-1:0] cnt_n;
    logic             cas_held, held_n;
    logic             armed, armed_n;
    logic             tmo, cviol;

    always_comb begin
        per_n   = per;
        cnt_n   = low_cnt;
        held_n  = cas_held;
        armed_n = armed;
        tmo     = 1'b0;
        cviol   = 1'b0;
        if (!cur.ras) begin
            if (edges.ras_fall) begin
                cnt_n   = CNT_W'(1);
                per_n   = '0;
                armed_n = 1'b0;
                if (edges.cas_pre_low)
                    per_n.entry = cas_held ? ENT_HIDDEN : (cur.we ? ENT_CBR : ENT_TEST);
            end else if (low_cnt != CNT_MAX) begin
                cnt_n = low_cnt + CNT_W'(1);
            end
            if (per_n.entry == ENT_ACCESS) begin
                if (edges.cas_fall) begin
                    if (per_n.ncas == 2'd0) per_n.wr_early = ~cur.we;
                    if (per_n.ncas != 2'd3) per_n.ncas = per_n.ncas + 2'd1;
                end
                if (per_n.ncas != 2'd0 && !cur.cas && !per_n.wr_early) begin
                    if (edges.we_fall) begin
                        if (per_n.oe_seen || !cur.oe) per_n.rmw = 1'b1;
                        else                          per_n.wr_late = 1'b1;
                    end
                    if (!cur.oe) per_n.oe_seen = 1'b1;
                end
                tmo = (limit != '0) && (cnt_n == limit) && (per_n.ncas < 2'd2);
            end
        end else begin
            if (edges.ras_rise)
                held_n = !cur.cas &&
                         ((per.entry == ENT_ACCESS && per.ncas != 2'd0) ||
                          per.entry == ENT_HIDDEN);
            else if (cur.cas)
                held_n = 1'b0;
            if (edges.cas_fall) armed_n = 1'b1;
            if (edges.cas_rise && armed) begin
                cviol   = 1'b1;
                armed_n = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per      <= '0;
            low_cnt  <= '0;
            cas_held <= 1'b0;
            armed    <= 1'b0;
            viol     <= 1'b0;
        end else begin
            per      <= per_n;
            low_cnt  <= cnt_n;
            cas_held <= held_n;
            armed    <= armed_n;
            viol     <= tmo | cviol;
        end
    end
endmodule

// File: rtl/dcc_reporter.sv
module dcc_reporter
    import dcc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SREF_CYC = 20000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_rise,
    input  period_t          per,
    input  logic [CNT_W-1:0] low_cnt,
    output logic             valid,
    output cyc_e             code
);
    localparam logic [CNT_W-1:0] SREF_L = CNT_W'(SREF_CYC);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            code  <= CYC_NONE;
        end else begin
            valid <= ras_rise;
            if (ras_rise) code <= classify(per, low_cnt > SREF_L);
        end
    end
endmodule

// File: rtl/dram_cycle_classifier.sv
module dram_cycle_classifier
    import dcc_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SREF_CYC = 20000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             oe_n,
    input  logic [CNT_W-1:0] max_low_clks,
    output logic             cyc_valid,
    output logic [3:0]       cyc_code,
    output logic             viol
);
    strobe_t          raw, cur;
    edge_t            edges;
    period_t          per;
    logic [CNT_W-1:0] low_cnt;
    cyc_e             code;

    assign raw = '{ras: ras_n, cas: cas_n, we: we_n, oe: oe_n};

    dcc_sampler u_smp (
        .clk(clk), .rst(rst), .raw(raw), .cur(cur), .edges(edges)
    );

    dcc_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst(rst), .cur(cur), .edges(edges), .limit(max_low_clks),
        .per(per), .low_cnt(low_cnt), .viol(viol)
    );

    dcc_reporter #(.CNT_W(CNT_W), .SREF_CYC(SREF_CYC)) u_rep (
        .clk(clk), .rst(rst), .ras_rise(edges.ras_rise), .per(per),
        .low_cnt(low_cnt), .valid(cyc_valid), .code(code)
    );

    assign cyc_code = code;
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker (
    input logic       clk,
    input logic       rst,
    input logic       ras_n,
    input logic       cyc_valid,
    input logic [3:0] cyc_code,
    input logic       viol
);
    assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |=> !cyc_valid);

    assert_valid_after_rise_R2: assert property (@(posedge clk) disable iff (rst)
        ($rose(ras_n) && !$past(rst)) |-> ##2 cyc_valid);

    assert_code_range_R1: assert property (@(posedge clk) disable iff (rst)
        cyc_valid |-> (cyc_code >= 4'd1 && cyc_code <= 4'd10));

    assert_code_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !cyc_valid |-> $stable(cyc_code));

    assert_viol_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        viol |=> !viol);
endmodule

bind dram_cycle_classifier dcc_checker u_chk (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cyc_valid(cyc_valid),
    .cyc_code(cyc_code), .viol(viol)
);

// File: tb/sim_dram_cycle_classifier.sv
`timescale 1ns/1ps
module sim_dram_cycle_classifier;
    localparam int CW   = 16;
    localparam int SREF = 40;

    localparam int K_READ = 0, K_EARLY = 1, K_LATE = 2, K_RMW = 3, K_PAGE = 4,
                   K_RONLY = 5, K_CBR = 6, K_TEST = 7, K_HIDDEN = 8;

    logic clk = 1'b0, rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [CW-1:0] max_low_clks = CW'(25);
    logic cyc_valid, viol;
    logic [3:0] cyc_code;

    int total = 0, bad = 0, nvalid = 0, nviol = 0;
    logic [3:0] got_code = 4'd0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dram_cycle_classifier #(.CNT_W(CW), .SREF_CYC(SREF)) u0 (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .max_low_clks(max_low_clks), .cyc_valid(cyc_valid),
        .cyc_code(cyc_code), .viol(viol)
    );

    always @(negedge clk) if (!rst) begin
        if (cyc_valid) begin got_code = cyc_code; nvalid++; end
        if (viol) nviol++;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic drv(input logic r, input logic c, input logic w, input logic o);
        ras_n = r; cas_n = c; we_n = w; oe_n = o;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_code(input int k, input int len);
        case (k)
            K_READ:   return 1;
            K_EARLY:  return 2;
            K_LATE:   return 3;
            K_RMW:    return 4;
            K_PAGE:   return 5;
            K_RONLY:  return 6;
            K_CBR:    return (len > SREF) ? 10 : 7;
            K_TEST:   return 8;
            default:  return 9;
        endcase
    endfunction

    function automatic string tag_of(input int k);
        case (k)
            K_READ, K_EARLY: return "R5";
            K_LATE, K_RMW:   return "R6";
            K_PAGE:          return "R7";
            K_RONLY:         return "R4";
            K_CBR:           return "R9";
            K_TEST:          return "R3";
            default:         return "R8";
        endcase
    endfunction

    task automatic do_read(input int a);
        drv(1'b0, 1'b1, 1'b1, 1'b1); step(a);
        drv(1'b0, 1'b0, 1'b1, 1'b0); step(a);
        drv(1'b1, 1'b0, 1'b1, 1'b0); step(1);
    endtask

    task automatic do_cycle(input int k, input int a, input int len);
        case (k)
            K_READ: do_read(a);
            K_EARLY: begin
                drv(1'b0, 1'b1, 1'b0, 1'b1); step(a);
                drv(1'b0, 1'b0, 1'b0, 1'b1); step(a);
                drv(1'b1, 1'b0, 1'b0, 1'b1); step(1);
            end
            K_LATE: begin
                drv(1'b0, 1'b1, 1'b1, 1'b1); step(a);
                drv(1'b0, 1'b0, 1'b1, 1'b1); step(a);
                drv(1'b0, 1'b0, 1'b0, 1'b1); step(a);
                drv(1'b1, 1'b0, 1'b0, 1'b1); step(1);
            end
            K_RMW: begin
                drv(1'b0, 1'b1, 1'b1, 1'b1); step(a);
                drv(1'b0, 1'b0, 1'b1, 1'b0); step(a);
                drv(1'b0, 1'b0, 1'b1, 1'b1); step(1);
                drv(1'b0, 1'b0, 1'b0, 1'b1); step(a);
                drv(1'b1, 1'b0, 1'b0, 1'b1); step(1);
            end
            K_PAGE: begin
                drv(1'b0, 1'b1, 1'b1, 1'b1); step(a);
                for (int i = 0; i < 2 + (a % 3); i++) begin
                    drv(1'b0, 1'b0, 1'b1, 1'b0); step(a);
                    drv(1'b0, 1'b1, 1'b1, 1'b0); step(a);
                end
                drv(1'b1, 1'b1, 1'b1, 1'b1); step(1);
            end
            K_RONLY: begin
                drv(1'b0, 1'b1, 1'b1, 1'b1); step(2 * a);
            end
            K_CBR, K_TEST: begin
                logic w;
                w = (k == K_TEST) ? 1'b0 : 1'b1;
                drv(1'b1, 1'b0, w, 1'b1); step(2);
                drv(1'b0, 1'b0, w, 1'b1); step((k == K_CBR) ? len : a);
                drv(1'b1, 1'b0, w, 1'b1); step(1);
            end
            default: begin
                do_read(a);
                step(a);
                drv(1'b0, 1'b0, 1'b1, 1'b1); step(a);
                drv(1'b1, 1'b0, 1'b1, 1'b1); step(1);
            end
        endcase
        drv(1'b1, 1'b1, 1'b1, 1'b1); step(4);
    endtask

    task automatic run_checked(input int k, input int a, input int len);
        int v0, x0, ev;
        v0 = nvalid; x0 = nviol;
        do_cycle(k, a, len);
        ev = (k == K_HIDDEN) ? 2 : 1;
        check(got_code == 4'(exp_code(k, len)), {tag_of(k), " code"}, got_code, exp_code(k, len));
        check(nvalid - v0 == ev, {tag_of(k), " valid count"}, nvalid - v0, ev);
        check(nviol == x0, "R11 no fault", nviol - x0, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v0, x0, r;
        r = $urandom(32'd4242);
        step(5);
        rst = 1'b0;
        step(1);
        check(cyc_valid == 1'b0, "R13 valid", cyc_valid, 0);
        check(cyc_code == 4'd0, "R13 code", cyc_code, 0);
        check(viol == 1'b0, "R13 viol", viol, 0);

        // R2 exact pulse timing
        drv(1'b0, 1'b1, 1'b1, 1'b1); step(3);
        drv(1'b0, 1'b0, 1'b1, 1'b0); step(3);
        drv(1'b1, 1'b0, 1'b1, 1'b0); step(1);
        check(cyc_valid == 1'b0, "R2 early", cyc_valid, 0);
        step(1);
        check(cyc_valid == 1'b1, "R2 pulse", cyc_valid, 1);
        check(cyc_code == 4'd1, "R2 code", cyc_code, 1);
        drv(1'b1, 1'b1, 1'b1, 1'b1); step(1);
        check(cyc_valid == 1'b0, "R2 width", cyc_valid, 0);
        check(cyc_code == 4'd1, "R1 hold", cyc_code, 1);
        step(4);

        // R9 boundaries
        run_checked(K_CBR, 2, SREF);
        run_checked(K_CBR, 2, SREF + 1);

        // R10 stray column pulse while row strobe is high
        v0 = nvalid; x0 = nviol;
        drv(1'b1, 1'b0, 1'b1, 1'b1); step(3);
        drv(1'b1, 1'b1, 1'b1, 1'b1); step(4);
        check(nviol - x0 == 1, "R10 fault", nviol - x0, 1);
        check(nvalid == v0, "R10 no cycle", nvalid - v0, 0);

        // R11 overlong read
        x0 = nviol;
        drv(1'b0, 1'b1, 1'b1, 1'b1); step(2);
        drv(1'b0, 1'b0, 1'b1, 1'b0); step(28);
        drv(1'b1, 1'b0, 1'b1, 1'b0); step(1);
        drv(1'b1, 1'b1, 1'b1, 1'b1); step(4);
        check(nviol - x0 == 1, "R11 timeout", nviol - x0, 1);
        check(got_code == 4'd1, "R11 code", got_code, 1);

        // R11 refresh periods are not timed
        run_checked(K_CBR, 2, 30);

        // R12 second fall on the limit sample, then one lower
        for (int lim = 7; lim >= 6; lim--) begin
            max_low_clks = CW'(lim);
            x0 = nviol;
            drv(1'b0, 1'b1, 1'b1, 1'b1); step(2);
            drv(1'b0, 1'b0, 1'b1, 1'b0); step(2);
            drv(1'b0, 1'b1, 1'b1, 1'b0); step(2);
            drv(1'b0, 1'b0, 1'b1, 1'b0); step(2);
            drv(1'b1, 1'b1, 1'b1, 1'b1); step(5);
            check(got_code == 4'd5, "R12 page code", got_code, 5);
            check(nviol - x0 == ((lim == 7) ? 0 : 1), "R12 limit race", nviol - x0, (lim == 7) ? 0 : 1);
        end

        // R12 limit zero disables
        max_low_clks = '0;
        x0 = nviol;
        drv(1'b0, 1'b1, 1'b1, 1'b1); step(40);
        drv(1'b1, 1'b1, 1'b1, 1'b1); step(4);
        check(nviol == x0, "R12 disabled", nviol - x0, 0);
        check(got_code == 4'd6, "R4 long", got_code, 6);
        max_low_clks = CW'(25);

        // Directed pass over every kind, then random mix
        for (int k = 0; k < 9; k++) run_checked(k, 3, 10);
        for (int i = 0; i < 250; i++) begin
            int k, a, len;
            k   = int'($urandom % 9);
            a   = 2 + int'($urandom % 4);
            len = 3 + int'($urandom % 70);
            run_checked(k, a, len);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule